// File: doc/BRIEF.md
# Interrupt Enable Register Port with Frame-Length Check

This block is a 16-bit serial slave port that reaches one register of a small system controller: a 12-bit interrupt enable word. The serial clock, chip select and data input are first resynchronised into the system clock domain. Each frame then carries a 4-bit header and a 12-bit payload. The header names a 2-bit register address, a readback select and a write flag. While the header is still being received, the port loads the word it will return. The returned word is either the live enable register or an echo of the last payload written to it.

A write takes effect only when chip select is released, and only if the master gave exactly 16 clock pulses. A frame of any other length is thrown away. In that case the port can flag the fault, depending on the enable bit for frame-length faults. The flag is an interrupt pulse during normal operation, or a reset request pulse while the controller is in its start-up or restart phase.

Top module: `spi_irq_port`

## Requirements
- R1: After reset, `ien` is 0, `miso`, `irq` and `rst_req` are 0, and the write echo is 0.
- R2: Data is sampled on rising `sck` edges, MSB first, while `cs_n` is low. Frame bits 15:14 are the address, and only address 2'b01 reaches the register. A frame with any other address writes nothing and returns all zeros.
- R3: When bit 12 is 1 in a 16-clock frame to address 01, bits 11:0 are written to `ien` at `cs_n` release. When bit 12 is 0, `ien` is left unchanged.
- R4: `miso` changes on falling `sck` edges and returns four zeros followed by a 12-bit word, MSB first. Bit 13 = 1 selects `ien`, and bit 13 = 0 selects the echo of the last accepted write payload. Both are the values from before the current frame's write.
- R5: A frame whose rising-edge count is not exactly 16 changes neither `ien` nor the echo.
- R6: On a wrong-length frame with `ien[8]` set, the port gives a one-cycle pulse. The pulse is on `irq` when `startup_mode` is 0 and on `rst_req` when it is 1. When `ien[8]` is clear there is no pulse. The value of `ien[8]` used is the one held before the frame.
- R7: Bit 2 of `ien` always reads 0, whatever is written. The echo keeps bit 2 as it was written.
- R8: The clock counter saturates at 31. Frames of 17 to 40 or more clocks, and frames with no clock at all, count as wrong length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select framing one access |
| mosi | input | 1 | Serial data in |
| startup_mode | input | 1 | 1 while the controller is in start-up or restart |
| miso | output | 1 | Serial data out |
| ien | output | 12 | Interrupt enable register; bit 8 enables frame-length faults |
| irq | output | 1 | One-cycle interrupt pulse for a frame-length fault |
| rst_req | output | 1 | One-cycle reset request for a frame-length fault |

## Verification
Two functions meet at the same `cs_n` release: the length check and the register commit. The length check decides whether a fault is reported, and it uses the fault enable held before the frame. The bench provokes this case with a 17-clock frame whose payload would set the fault enable while the enable is currently clear. A correct port reports nothing and leaves `ien` at zero. In the opposite case, a 16-clock frame that clears the enable commits without a pulse. The pulse counters and the `ien` port are read after each release.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   // Header sent ahead of the payload, most significant field first.
   typedef struct packed {
      logic [1:0] addr;  // register address
      logic       rrs;   // 1: return live enables, 0: return write echo
      logic       ro;    // 1: commit payload, 0: read only
   } hdr_t;

   localparam int HDR_W = $bits(hdr_t);

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= (chain << 1) | STAGES'(din);
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_port_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int CNT_W  = 5,
   localparam int FRAME_W = HDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_rise,
   input  logic               sck_fall,
   input  logic               cs_fall,
   input  logic               cs_rise,
   input  logic               mosi,
   input  logic [DATA_W-1:0]  rd_word,
   output hdr_t               hdr_now,
   output logic               miso,
   output logic               done,
   output logic               len_ok,
   output logic [FRAME_W-1:0] frame
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic               active;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] rx;
   logic [FRAME_W-1:0] tx;

   // Header as it stands once the current bit is shifted in.
   assign hdr_now = hdr_t'({rx[HDR_W-2:0], mosi});
   assign miso    = active & tx[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         rx     <= '0;
         tx     <= '0;
         done   <= 1'b0;
         len_ok <= 1'b0;
         frame  <= '0;
      end else begin
         done <= 1'b0;
         if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
         end else if (active) begin
            if (cs_rise) begin
               active <= 1'b0;
               done   <= 1'b1;
               len_ok <= (cnt == CNT_FULL);
               frame  <= rx;
               tx     <= '0;
            end else if (sck_rise) begin
               rx <= {rx[FRAME_W-2:0], mosi};
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
               // The next falling edge moves rd_word's MSB to the output bit.
               if (cnt == CNT_HDR) tx <= {1'b0, rd_word, {(HDR_W-1){1'b0}}};
            end else if (sck_fall) begin
               tx <= {tx[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

   a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cs_fall && !cs_rise && sck_rise && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

   a_r4_header_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt <= CNT_HDR) |-> !miso);

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/ien_regfile.sv
module ien_regfile
   import spi_port_pkg::*;
#(
   parameter int         DATA_W     = 12,
   parameter logic [1:0] IEN_ADDR   = 2'b01,
   parameter int         SPIFIE_BIT = 8,
   parameter int         RSV_BIT    = 2,
   localparam int        FRAME_W    = HDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic               len_ok,
   input  logic [FRAME_W-1:0] frame,
   input  hdr_t               hdr_now,
   input  logic               startup_mode,
   output logic [DATA_W-1:0]  ien,
   output logic [DATA_W-1:0]  rd_word,
   output logic               irq,
   output logic               rst_req
);

   logic [DATA_W-1:0] echo;
   logic [DATA_W-1:0] rsv_mask;
   hdr_t              fh;
   logic [DATA_W-1:0] payload;
   logic              wr_en;
   logic              fault;

   generate
      if (RSV_BIT >= 0) begin : g_rsv
         assign rsv_mask = DATA_W'(1) << RSV_BIT;
      end else begin : g_no_rsv
         assign rsv_mask = '0;
      end
   endgenerate

   assign fh      = hdr_t'(frame[FRAME_W-1 -: HDR_W]);
   assign payload = frame[DATA_W-1:0];
   assign wr_en   = done & len_ok & (fh.addr == IEN_ADDR) & fh.ro;
   assign fault   = done & ~len_ok & ien[SPIFIE_BIT];

   always_comb begin
      if (hdr_now.addr != IEN_ADDR) rd_word = '0;
      else if (hdr_now.rrs)         rd_word = ien;
      else                          rd_word = echo;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien     <= '0;
         echo    <= '0;
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         if (wr_en) begin
            ien  <= payload & ~rsv_mask;
            echo <= payload;
         end
         irq     <= fault & ~startup_mode;
         rst_req <= fault & startup_mode;
      end
   end

   a_r5_bad_len_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !len_ok) |=> ($stable(ien) && $stable(echo)));

   a_r3_read_only_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !frame[FRAME_W-HDR_W]) |=> $stable(ien));

   a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && rst_req));

   a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || rst_req) |-> $past(ien[SPIFIE_BIT]));

   a_r7_rsv_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ien & rsv_mask) == '0);

endmodule

// File: rtl/spi_irq_port.sv
module spi_irq_port
   import spi_port_pkg::*;
#(
   parameter int         DATA_W      = 12,
   parameter int         CNT_W       = 5,
   parameter int         SYNC_STAGES = 2,
   parameter logic [1:0] IEN_ADDR    = 2'b01,
   parameter int         SPIFIE_BIT  = 8,
   parameter int         RSV_BIT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              mosi,
   input  logic              startup_mode,
   output logic              miso,
   output logic [DATA_W-1:0] ien,
   output logic              irq,
   output logic              rst_req
);

   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_MAX <= FRAME_W) begin : g_bad_cnt
         $error("CNT_W too small to detect overlong frames");
      end
      if (SPIFIE_BIT >= DATA_W || RSV_BIT >= DATA_W) begin : g_bad_bit
         $error("enable bit positions outside payload");
      end
   endgenerate

   logic sck_s, cs_s, mosi_s;
   logic sck_d, cs_d;
   logic sck_rise, sck_fall, cs_fall, cs_rise;

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck
      (.clk(clk), .rst_n(rst_n), .din(sck), .dout(sck_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs
      (.clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi
      (.clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign cs_fall  = ~cs_s & cs_d;
   assign cs_rise  = cs_s & ~cs_d;

   hdr_t               hdr_now;
   logic [DATA_W-1:0]  rd_word;
   logic               done, len_ok;
   logic [FRAME_W-1:0] frame;

   spi_frame_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_fall(cs_fall), .cs_rise(cs_rise),
      .mosi(mosi_s), .rd_word(rd_word), .hdr_now(hdr_now),
      .miso(miso), .done(done), .len_ok(len_ok), .frame(frame)
   );

   ien_regfile #(
      .DATA_W(DATA_W), .IEN_ADDR(IEN_ADDR),
      .SPIFIE_BIT(SPIFIE_BIT), .RSV_BIT(RSV_BIT)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .done(done), .len_ok(len_ok),
      .frame(frame), .hdr_now(hdr_now), .startup_mode(startup_mode),
      .ien(ien), .rd_word(rd_word), .irq(irq), .rst_req(rst_req)
   );

endmodule

// File: tb/sim_spi_irq_port.sv
module sim_spi_irq_port;

   typedef struct packed {
      int          n;
      logic [15:0] word;
      logic        mode;
      logic [11:0] exp_ien;
      int          exp_irq;
      int          exp_rst;
      int          req;
   } vec_t;

   localparam int HALF = 8;
   localparam int NV   = 14;
   localparam vec_t VECS [NV] = '{
      '{16, 16'h50A5, 1'b0, 12'h0A1, 0, 0, 7}, // R7 reserved bit dropped
      '{16, 16'h6000, 1'b0, 12'h0A1, 0, 0, 4}, // R4 live enables
      '{16, 16'h4000, 1'b0, 12'h0A1, 0, 0, 4}, // R4 echo keeps bit 2
      '{15, 16'h5FFF, 1'b0, 12'h0A1, 0, 0, 5}, // R5 short frame
      '{16, 16'h5100, 1'b0, 12'h100, 0, 0, 3}, // R3 write, old echo out
      '{17, 16'h5FFF, 1'b0, 12'h100, 1, 0, 6}, // R6 irq
      '{12, 16'h5FFF, 1'b1, 12'h100, 0, 1, 6}, // R6 reset request
      '{16, 16'h9FFF, 1'b0, 12'h100, 0, 0, 2}, // R2 foreign address
      '{16, 16'h7FFB, 1'b0, 12'hFFB, 0, 0, 4}, // R4 old content on write
      '{40, 16'h5000, 1'b0, 12'hFFB, 1, 0, 8}, // R8 saturation
      '{ 0, 16'h5000, 1'b0, 12'hFFB, 1, 0, 8}, // R8 no clocks
      '{16, 16'h6FF0, 1'b0, 12'hFFB, 0, 0, 3}, // R3 read only
      '{16, 16'h5000, 1'b0, 12'h000, 0, 0, 3}, // R3 clear all
      '{17, 16'h5100, 1'b0, 12'h000, 0, 0, 6}  // R6 enable before frame
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        cs_n = 1'b1;
   logic        mosi = 1'b0;
   logic        startup_mode = 1'b0;
   logic        miso;
   logic [11:0] ien;
   logic        irq, rst_req;

   int checks = 0;
   int fails  = 0;
   int irq_cnt = 0;
   int rst_cnt = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   spi_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .startup_mode(startup_mode), .miso(miso), .ien(ien),
      .irq(irq), .rst_req(rst_req)
   );

   always @(posedge clk) begin
      if (irq)     irq_cnt <= irq_cnt + 1;
      if (rst_req) rst_cnt <= rst_cnt + 1;
   end

   task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input int n, input logic [15:0] w, input logic mode,
                       output logic [15:0] got);
      got = '0;
      startup_mode = mode;
      idle(4);
      irq_cnt = 0;
      rst_cnt = 0;
      cs_n = 1'b0;
      idle(HALF);
      for (int i = 0; i < n; i++) begin
         mosi = (i < 16) ? w[15-i] : 1'b0;
         idle(HALF);
         if (i < 16) got[15-i] = miso;
         sck = 1'b1;
         idle(HALF);
         sck = 1'b0;
      end
      idle(HALF);
      cs_n = 1'b1;
      idle(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [11:0] m_ien;
      logic [11:0] m_echo;
      logic [15:0] got;
      logic [11:0] exp12;
      m_ien  = '0;
      m_echo = '0;
      idle(5);
      rst_n = 1'b1;
      idle(3);
      // R1 reset state
      chk(ien == 12'h000, 1, 32'(ien), 0);
      chk(miso == 1'b0 && irq == 1'b0 && rst_req == 1'b0, 1,
          {29'b0, miso, irq, rst_req}, 0);

      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         if (t.word[15:14] == 2'b01) exp12 = t.word[13] ? m_ien : m_echo;
         else                        exp12 = '0;
         xfer(t.n, t.word, t.mode, got);
         if (t.n == 16) chk(got == {4'b0, exp12}, t.req, 32'(got), 32'({4'b0, exp12}));
         chk(ien == t.exp_ien, t.req, 32'(ien), 32'(t.exp_ien));
         chk(irq_cnt == t.exp_irq, t.req, irq_cnt, t.exp_irq);
         chk(rst_cnt == t.exp_rst, t.req, rst_cnt, t.exp_rst);
         if (t.n == 16 && t.word[15:12] == 4'b0101 || t.n == 16 && t.word[15:12] == 4'b0111)
            m_echo = t.word[11:0];
         m_ien = t.exp_ien;
      end

      // R6 enable set, wrong length in start-up mode, no irq leaks
      xfer(16, 16'h5100, 1'b0, got);
      xfer(3, 16'hFFFF, 1'b1, got);
      chk(rst_cnt == 1 && irq_cnt == 0, 6, {rst_cnt[15:0], irq_cnt[15:0]}, 32'h00010000);

      // R1 mid-run reset clears enables and echo
      xfer(16, 16'h5ABC, 1'b0, got);
      @(negedge clk) rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      chk(ien == 12'h000, 1, 32'(ien), 0);
      xfer(16, 16'h4000, 1'b0, got);
      chk(got == 16'h0000, 1, 32'(got), 0);

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule